// File: doc/BRIEF.md
# Read/Write Bus Mode Arbiter

This block sits beside the read and write queues of a memory controller and decides, cycle by cycle, whether the shared data bus carries read bursts or drains buffered writes. It watches the occupancy of both queues, a drain request and a strobe for each completed write burst. From these it produces the current bus mode, a busy flag for the write-to-read turnaround, and at most one burst grant per cycle.

Writes are drained opportunistically. When no read is waiting and the write queue holds more than a low watermark, the block switches to writes. A high watermark forces a switch even while reads are pending. Once writing, the block keeps going until one of three things happens: the write queue is empty, the queue has dropped below the low watermark with no drain request, or reads are waiting and a minimum number of writes has completed.

Every return to read mode blocks reads for a fixed number of turnaround cycles. Both watermarks are derived at elaboration from the write-queue depth and two percentages.

Top module: `rw_bus_mode_ctl`

## Requirements
- R1: Each watermark in entries is the write-queue depth times its percentage divided by 100, truncated. The defaults (depth 32, 85 and 50 percent) give a high mark of 27 and a low mark of 16. A parameter set whose low percentage is not strictly below the high percentage is flagged at elaboration.
- R2: In read mode with the read count at 0, the block enters write mode one clock later when the write count is non-zero and either above the low mark or accompanied by `drain_req`. At exactly the low mark with no drain request it stays in read mode.
- R3: In read mode, a write count at or above the high mark forces write mode one clock later even when reads are pending. In that cycle `rd_grant` is 0.
- R4: In write mode a per-drain tally counts completed writes (`wr_done` high). With reads waiting and the write count at or above the low mark, the block leaves write mode only on the completed write that brings the tally to `MIN_WR_SWITCH` (16 by default).
- R5: In write mode the block returns to read mode one clock after a cycle in which the write count is 0, or in which `wr_done` is high with the write count below the low mark and `drain_req` low.
- R6: While `drain_req` is high, a non-zero write count below the low mark does not end write mode.
- R7: Every return to read mode clears the tally. It also holds `turn_busy` high for exactly `WTR_CYC` cycles (4 by default), starting the cycle after the switch. `rd_grant` stays 0 during those cycles.
- R8: After reset the block is in read mode (`mode_wr` = 0), with the tally cleared and `turn_busy` low.
- R9: `rd_grant` is 1 exactly when the block is in read mode, is not in turnaround, has a non-zero read count and is not entering write mode. `rd_grant` and `wr_grant` are never both 1.
- R10: `wr_grant` is 1 exactly when the block is in write mode and the write count is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_count | input | RQ_W (6) | Read-queue occupancy |
| wr_count | input | WQ_W (6) | Write-queue occupancy, excluding a burst completed this cycle |
| drain_req | input | 1 | Request to empty the write queue |
| wr_done | input | 1 | One write burst completed this cycle |
| mode_wr | output | 1 | 1 = write mode, 0 = read mode |
| turn_busy | output | 1 | Write-to-read turnaround in progress |
| wr_grant | output | 1 | A write burst may issue this cycle |
| rd_grant | output | 1 | A read burst may issue this cycle |

## Verification
The two grants follow the inputs combinationally in the same cycle. Mode changes, the tally and the start of `turn_busy` show one clock after the cycle whose inputs decided them. The bench therefore drives inputs at the falling edge and compares the grants one nanosecond later against a reference model updated from the same values. Mode and turnaround checks on directed sequences are taken one nanosecond after the following rising edge. This keeps each check aligned with the cycle in which its result is due.

// File: rtl/rwm_pkg.sv
package rwm_pkg;

    typedef enum logic {
        BUS_RD = 1'b0,
        BUS_WR = 1'b1
    } bus_mode_e;

    typedef struct packed {
        logic wq_empty;
        logic rq_empty;
        logic above_lo;
        logic below_lo;
        logic at_hi;
    } occ_flags_t;

    function automatic int unsigned pct_mark(input int unsigned depth, input int unsigned pct);
        return (depth * pct) / 100;
    endfunction

endpackage

// File: rtl/rwm_occ_cmp.sv
module rwm_occ_cmp
    import rwm_pkg::*;
#(
    parameter int WQ_W    = 6,
    parameter int RQ_W    = 6,
    parameter int HI_MARK = 27,
    parameter int LO_MARK = 16
) (
    input  logic [RQ_W-1:0] rd_count,
    input  logic [WQ_W-1:0] wr_count,
    output occ_flags_t      flags
);
    localparam logic [WQ_W-1:0] HI_V = HI_MARK[WQ_W-1:0];
    localparam logic [WQ_W-1:0] LO_V = LO_MARK[WQ_W-1:0];

    always_comb begin
        flags.wq_empty = (wr_count == '0);
        flags.rq_empty = (rd_count == '0);
        flags.above_lo = (wr_count > LO_V);
        flags.below_lo = (wr_count < LO_V);
        flags.at_hi    = (wr_count >= HI_V);
    end
endmodule

// File: rtl/rwm_turnaround.sv
module rwm_turnaround #(
    parameter int WTR_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    output logic busy
);
    generate
        if (WTR_CYC == 0) begin : g_none
            assign busy = 1'b0;
        end else begin : g_cnt
            localparam int TW = $clog2(WTR_CYC + 1);
            localparam logic [TW-1:0] LOAD_V = WTR_CYC[TW-1:0];
            logic [TW-1:0] remain;

            always_ff @(posedge clk) begin
                if (rst)
                    remain <= '0;
                else if (load)
                    remain <= LOAD_V;
                else if (remain != '0)
                    remain <= remain - 1'b1;
            end

            assign busy = (remain != '0);
        end
    endgenerate
endmodule

// File: rtl/rwm_burst_tally.sv
module rwm_burst_tally #(
    parameter int MIN_WR_SWITCH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic inc,
    output logic hit_next
);
    localparam int CW = $clog2(MIN_WR_SWITCH + 1);
    localparam logic [CW-1:0] MAX_V = MIN_WR_SWITCH[CW-1:0];
    localparam logic [CW-1:0] NEAR_V = MAX_V - 1'b1;

    logic [CW-1:0] tally;

    always_ff @(posedge clk) begin
        if (rst || clear)
            tally <= '0;
        else if (inc && tally != MAX_V)
            tally <= tally + 1'b1;
    end

    // true when the write completing now reaches the minimum
    assign hit_next = (tally >= NEAR_V);
endmodule

// File: rtl/rw_bus_mode_ctl.sv
module rw_bus_mode_ctl
    import rwm_pkg::*;
#(
    parameter int WQ_DEPTH      = 32,
    parameter int RQ_DEPTH      = 32,
    parameter int HI_PCT        = 85,
    parameter int LO_PCT        = 50,
    parameter int MIN_WR_SWITCH = 16,
    parameter int WTR_CYC       = 4,
    localparam int WQ_W         = $clog2(WQ_DEPTH + 1),
    localparam int RQ_W         = $clog2(RQ_DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RQ_W-1:0] rd_count,
    input  logic [WQ_W-1:0] wr_count,
    input  logic            drain_req,
    input  logic            wr_done,
    output logic            mode_wr,
    output logic            turn_busy,
    output logic            wr_grant,
    output logic            rd_grant
);
    localparam int HI_MARK = int'(pct_mark(WQ_DEPTH, HI_PCT));
    localparam int LO_MARK = int'(pct_mark(WQ_DEPTH, LO_PCT));

    bus_mode_e  mode_q;
    occ_flags_t occ;
    logic       go_write;
    logic       leave_write;
    logic       tally_hit;
    logic       tally_inc;

    rwm_occ_cmp #(
        .WQ_W(WQ_W), .RQ_W(RQ_W), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)
    ) u_occ (
        .rd_count(rd_count), .wr_count(wr_count), .flags(occ)
    );

    rwm_burst_tally #(.MIN_WR_SWITCH(MIN_WR_SWITCH)) u_tally (
        .clk(clk), .rst(rst), .clear(leave_write), .inc(tally_inc), .hit_next(tally_hit)
    );

    rwm_turnaround #(.WTR_CYC(WTR_CYC)) u_wtr (
        .clk(clk), .rst(rst), .load(leave_write), .busy(turn_busy)
    );

    always_comb begin
        go_write = (mode_q == BUS_RD) && !occ.wq_empty &&
                   (occ.at_hi || (occ.rq_empty && (occ.above_lo || drain_req)));
        leave_write = (mode_q == BUS_WR) &&
                      (occ.wq_empty ||
                       (wr_done && ((occ.below_lo && !drain_req) ||
                                    (!occ.rq_empty && tally_hit))));
        tally_inc = (mode_q == BUS_WR) && wr_done && !leave_write;
        wr_grant  = (mode_q == BUS_WR) && !occ.wq_empty;
        rd_grant  = (mode_q == BUS_RD) && !turn_busy && !occ.rq_empty && !go_write;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= BUS_RD;
        else if (go_write)
            mode_q <= BUS_WR;
        else if (leave_write)
            mode_q <= BUS_RD;
    end

    assign mode_wr = (mode_q == BUS_WR);
endmodule

// File: rtl/rwm_chk.sv
module rwm_chk #(
    parameter int WQ_W    = 6,
    parameter int RQ_W    = 6,
    parameter int HI_MARK = 27,
    parameter int HI_PCT  = 85,
    parameter int LO_PCT  = 50
) (
    input logic            clk,
    input logic            rst,
    input logic [RQ_W-1:0] rd_count,
    input logic [WQ_W-1:0] wr_count,
    input logic            drain_req,
    input logic            wr_done,
    input logic            mode_wr,
    input logic            turn_busy,
    input logic            wr_grant,
    input logic            rd_grant
);
    localparam logic [WQ_W-1:0] HI_V = HI_MARK[WQ_W-1:0];

    // R1
    initial begin
        pct_order_chk: assert (LO_PCT < HI_PCT)
            else $error("low watermark percentage must be below high percentage");
    end

    // R9
    grant_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_grant, rd_grant}));

    // R10
    wr_grant_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        wr_grant |-> (wr_count != '0) && mode_wr);

    // R9
    rd_grant_legal_chk: assert property (@(posedge clk) disable iff (rst)
        rd_grant |-> (rd_count != '0) && !turn_busy && !mode_wr);

    // R3
    hi_force_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_wr && wr_count >= HI_V) |=> mode_wr);

    // R5
    empty_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && wr_count == '0) |=> !mode_wr);

    // R6
    drain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_wr && drain_req && !wr_done && wr_count != '0) |=> mode_wr);

    // R7
    turn_on_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(mode_wr) |-> turn_busy);
endmodule

bind rw_bus_mode_ctl rwm_chk #(
    .WQ_W(WQ_W), .RQ_W(RQ_W), .HI_MARK(HI_MARK), .HI_PCT(HI_PCT), .LO_PCT(LO_PCT)
) u_chk (
    .clk(clk), .rst(rst), .rd_count(rd_count), .wr_count(wr_count),
    .drain_req(drain_req), .wr_done(wr_done), .mode_wr(mode_wr),
    .turn_busy(turn_busy), .wr_grant(wr_grant), .rd_grant(rd_grant)
);

// File: tb/sim_rw_bus_mode_ctl.sv
`timescale 1ns/1ps
module sim_rw_bus_mode_ctl;
    localparam int WQ_DEPTH = 32;
    localparam int RQ_DEPTH = 32;
    localparam int HI_PCT   = 85;
    localparam int LO_PCT   = 50;
    localparam int MIN_SW   = 16;
    localparam int WTR      = 4;
    localparam int WQ_W     = $clog2(WQ_DEPTH + 1);
    localparam int RQ_W     = $clog2(RQ_DEPTH + 1);
    localparam int HI       = (WQ_DEPTH * HI_PCT) / 100;
    localparam int LO       = (WQ_DEPTH * LO_PCT) / 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [RQ_W-1:0] rd_count = '0;
    logic [WQ_W-1:0] wr_count = '0;
    logic drain_req = 1'b0;
    logic wr_done = 1'b0;
    logic mode_wr, turn_busy, wr_grant, rd_grant;

    always #10 clk = ~clk;

    rw_bus_mode_ctl #(
        .WQ_DEPTH(WQ_DEPTH), .RQ_DEPTH(RQ_DEPTH), .HI_PCT(HI_PCT), .LO_PCT(LO_PCT),
        .MIN_WR_SWITCH(MIN_SW), .WTR_CYC(WTR)
    ) u0 (
        .clk(clk), .rst(rst), .rd_count(rd_count), .wr_count(wr_count),
        .drain_req(drain_req), .wr_done(wr_done), .mode_wr(mode_wr),
        .turn_busy(turn_busy), .wr_grant(wr_grant), .rd_grant(rd_grant)
    );

    int checks = 0;
    int fails  = 0;
    bit m_wr   = 1'b0;
    int m_cnt  = 0;
    int m_wtr  = 0;
    bit finished = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_go(input int rd, input int wr, input bit dr);
        return !m_wr && wr != 0 && (wr >= HI || (rd == 0 && (wr > LO || dr)));
    endfunction

    function automatic bit exp_leave(input int rd, input int wr, input bit dr, input bit dn);
        return m_wr && (wr == 0 ||
               (dn && ((wr < LO && !dr) || (rd != 0 && m_cnt + 1 >= MIN_SW))));
    endfunction

    task automatic step(input int rd, input int wr, input bit dr, input bit dn, input string tag);
        bit go, lv, e_wg, e_rg;
        @(negedge clk);
        rd_count  = RQ_W'(rd);
        wr_count  = WQ_W'(wr);
        drain_req = dr;
        wr_done   = dn;
        #1;
        go   = exp_go(rd, wr, dr);
        lv   = exp_leave(rd, wr, dr, dn);
        e_wg = m_wr && wr != 0;
        e_rg = !m_wr && m_wtr == 0 && rd != 0 && !go;
        chk({tag, " R2/R3/R4/R5/R6 mode"}, int'(mode_wr), int'(m_wr));
        chk({tag, " R7 turn_busy"}, int'(turn_busy), int'(m_wtr != 0));
        chk({tag, " R10 wr_grant"}, int'(wr_grant), int'(e_wg));
        chk({tag, " R9 rd_grant"}, int'(rd_grant), int'(e_rg));
        if (m_wr && dn && !lv && m_cnt < MIN_SW) m_cnt++;
        if (lv) m_cnt = 0;
        if (lv) m_wtr = WTR;
        else if (m_wtr > 0) m_wtr--;
        if (go) m_wr = 1'b1;
        else if (lv) m_wr = 1'b0;
    endtask

    task automatic after_edge_mode(input string tag, input bit exp);
        @(posedge clk);
        #1;
        chk(tag, int'(mode_wr), int'(exp));
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R8 reset state
        chk("R8 reset mode", int'(mode_wr), 0);
        chk("R8 reset turn_busy", int'(turn_busy), 0);
        chk("R8 reset wr_grant", int'(wr_grant), 0);
        rst = 1'b0;

        // R1 / R3: high mark at 27 forces writes with reads pending
        step(5, HI - 1, 0, 0, "R1 below high");
        after_edge_mode("R1 one below high mark stays read", 1'b0);
        step(5, HI, 0, 0, "R3 at high");
        after_edge_mode("R3 forced write at high mark", 1'b1);

        // R4: minimum write count before yielding to waiting reads
        for (int i = 0; i < MIN_SW - 1; i++) step(5, 20, 0, 1, "R4 drain");
        after_edge_mode("R4 stays before minimum", 1'b1);
        step(5, 20, 0, 1, "R4 last");
        after_edge_mode("R4 yields at minimum", 1'b0);
        chk("R7 turnaround starts", int'(turn_busy), 1);
        for (int i = 0; i < WTR; i++) step(5, 20, 0, 0, "R7 turnaround window");
        step(5, 20, 0, 0, "R7 after turnaround");
        chk("R7 read granted after turnaround", int'(rd_grant), 1);

        // R2 / R5: opportunistic entry above low mark, exit below it
        step(0, LO, 0, 0, "R2 at low");
        after_edge_mode("R2 at low mark no entry", 1'b0);
        step(0, LO + 1, 0, 0, "R2 above low");
        after_edge_mode("R2 entry above low mark", 1'b1);
        step(0, LO - 1, 0, 1, "R5 below low");
        after_edge_mode("R5 exit below low mark", 1'b0);

        // R6: drain request keeps writing small occupancies
        for (int i = 0; i < WTR; i++) step(0, 0, 0, 0, "R7 idle");
        step(0, 3, 1, 0, "R6 drain entry");
        after_edge_mode("R6 drain entry", 1'b1);
        step(0, 2, 1, 1, "R6 hold");
        after_edge_mode("R6 stays while draining", 1'b1);
        step(0, 0, 1, 0, "R5 empty");
        after_edge_mode("R5 exit on empty queue", 1'b0);

        // random traffic against the reference model
        for (int i = 0; i < 4000; i++) begin
            int rd, wr;
            bit dr, dn;
            rd = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(1, RQ_DEPTH));
            wr = ($urandom_range(0, 4) == 0) ? int'($urandom_range(0, 3))
                                             : int'($urandom_range(0, WQ_DEPTH));
            dr = ($urandom_range(0, 7) == 0);
            dn = m_wr && wr != 0 && ($urandom_range(0, 1) == 1);
            step(rd, wr, dr, dn, "random");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog R8 actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule